// File: doc/BRIEF.md
# SPI Slave with Phase-Zero Byte Framing

This block is the target (slave) end of an SPI link. It is clocked by a fast system clock. The serial clock, the select line and the master's data line are brought into that clock domain through synchronizers, and every serial event is found by edge detection on the synchronized copies. Both clock polarities and both clock phases are supported. Bytes are eight bits long and are shifted most significant bit first.

On the parallel side, a write strobe loads a transmit holding register. Each complete received byte appears on a receive data output together with a one-cycle valid pulse. The shift register takes data from the holding register only while the block is deselected, or at the moment a byte completes. A write made during a byte therefore leaves that byte untouched and goes out in the next one.

In phase-zero mode, each byte is framed by its own select pulse. The falling select edge puts the first bit on the output before any clock edge arrives. The block then ignores further clock edges until select has gone high and low again. In phase-one mode, select may stay low across any number of bytes. The output enable follows the raw select pin, so a deselected slave never drives the shared return line.

Top module: `spi_target_port`

## Requirements
- R1: `miso_oe_o` is 1 exactly while `ss_ni` is 0 and 0 while `ss_ni` is 1, with no clock delay.
- R2: While `ss_ni` is high, the shift register keeps loading from the transmit holding register. When `ss_ni` falls, `miso_o` already shows bit 7 of the byte to be sent, before the first serial clock edge.
- R3: With phase 0 (`cpha_i`=0), data is captured on the first serial clock edge and on every second edge after it, and the next output bit is presented on the edges in between. After 8 captures, the byte received (first bit in bit 7) appears on `rx_data_o`.
- R4: With phase 0, once 8 bits have been captured, further serial clock edges are ignored until `ss_ni` goes high and falls again. No second valid pulse is produced and `rx_data_o` is unchanged.
- R5: A write to the transmit holding register while a byte is in progress does not alter the bits of that byte. The new value is sent in the following byte.
- R6: If no write occurs between two bytes, the previous transmit value is sent again.
- R7: `cpol_i` gives the idle level of the serial clock: 0 means it idles low and 1 means it idles high. The leading edge is the edge that leaves the idle level. All four combinations of polarity and phase transfer data correctly in both directions.
- R8: With phase 1 (`cpha_i`=1), the output changes on leading edges and data is captured on trailing edges. Several bytes may be transferred under one low period of `ss_ni`, and each byte takes the holding register value present when the previous byte completed.
- R9: If `ss_ni` rises before 8 bits have been captured, the partial byte is dropped and no valid pulse is produced. The next transfer starts again at bit 7.
- R10: `rx_valid_o` is a single-cycle pulse. It is raised on the third system clock edge after the final capture edge appears at the pin. `rx_data_o` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the serial clock rate |
| rst_ni | input | 1 | Synchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase: 0 = capture on leading edge, 1 = capture on trailing edge |
| sclk_i | input | 1 | Serial clock from the master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| tx_data_i | input | DATA_W | Value for the transmit holding register |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| rx_data_o | output | DATA_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle pulse when a byte completes |

## Verification
Every serial input passes through two synchronizer stages and one edge-detect register. The receive-valid pulse is therefore checked at exactly the third system clock edge after the final capture edge is driven, one cycle before it, and one cycle after it. After each output-changing edge, the bench allows four system cycles before it samples `miso_o` as the master would, which is one more than the three-edge update path. The output enable is sampled 1 ns after the select pin changes, because it has no register in its path. The number of valid pulses is compared before and after partial bytes and after extra clock edges, to confirm that no pulse appears.

// File: rtl/spt_pkg.sv
// Shared definitions for the SPI target port.
// Assumes: one serial event at most per system clock cycle.
package spt_pkg;

    // Default synchronizer depth for the serial inputs.
    localparam int unsigned SPT_SYNC_DEPTH = 2;

    // Serial events as seen in the system clock domain.
    typedef struct packed {
        logic sel;      // slave selected (synchronized select is low)
        logic capture;  // sample the master's data line now
        logic launch;   // present the next output bit now
        logic data;     // synchronized master data
    } spt_evt_t;

endpackage

// File: rtl/spt_sync.sv
// Multi-bit synchronizer: each channel has its own flop chain.
// Assumes: channels are independent, and STAGES is at least 2.
module spt_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH = 3,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar c = 0; c < WIDTH; c++) begin : g_chan
        logic [STAGES-1:0] stage_q;

        // Shift the asynchronous input through the chain of flops.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                stage_q <= {STAGES{RESET_VAL[c]}};
            end else begin
                stage_q <= {stage_q[STAGES-2:0], async_i[c]};
            end
        end

        assign sync_o[c] = stage_q[STAGES-1];
    end

endmodule

// File: rtl/spt_edge.sv
// Edge detector: converts the synchronized serial clock into capture
// and launch events, using the polarity and phase settings.
// Assumes: polarity and phase change only while the slave is deselected.
module spt_edge
    import spt_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     cpol_i,
    input  logic     cpha_i,
    input  logic     sclk_s_i,
    input  logic     ss_s_i,
    input  logic     mosi_s_i,
    output spt_evt_t evt_o
);

    logic sclk_q;
    logic rise, fall, lead, trail;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s_i;
        end
    end

    // Classify the edge: the leading edge leaves the idle level.
    always_comb begin
        rise  = sclk_s_i & ~sclk_q;
        fall  = ~sclk_s_i & sclk_q;
        lead  = cpol_i ? fall : rise;
        trail = cpol_i ? rise : fall;
        evt_o.sel     = ~ss_s_i;
        evt_o.capture = ~ss_s_i & (cpha_i ? trail : lead);
        evt_o.launch  = ~ss_s_i & (cpha_i ? lead : trail);
        evt_o.data    = mosi_s_i;
    end

endmodule

// File: rtl/spt_txhold.sv
// Transmit holding register: keeps the last value written.
// Assumes: a write strobe lasts at least one system cycle.
module spt_txhold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] hold_o
);

    // Load a new value on each write and keep it otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hold_o <= '0;
        end else if (wr_i) begin
            hold_o <= data_i;
        end
    end

endmodule

// File: rtl/spt_engine.sv
// Shift engine: transmit and receive shift registers, the bit counter,
// byte completion, and the phase-zero lockout after a full byte.
// Assumes: capture and launch events never occur in the same cycle.
module spt_engine
    import spt_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpha_i,
    input  spt_evt_t          evt_i,
    input  logic [DATA_W-1:0] hold_i,
    output logic              tx_msb_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);

    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              last_cap;
    logic [DATA_W-1:0] rx_next;

    // Recognize the capture edge that completes a byte.
    always_comb begin
        last_cap = evt_i.capture & ~done_q & (cnt_q == LAST_BIT);
        rx_next  = {rx_sh_q[DATA_W-2:0], evt_i.data};
    end

    // Shift, count, and finish bytes. While deselected, keep loading
    // the shift register from the holding register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tx_sh_q    <= '0;
            rx_sh_q    <= '0;
            cnt_q      <= '0;
            done_q     <= 1'b0;
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (!evt_i.sel) begin
                cnt_q   <= '0;
                done_q  <= 1'b0;
                tx_sh_q <= hold_i;
            end else if (!done_q) begin
                if (evt_i.capture) begin
                    rx_sh_q <= rx_next;
                    if (last_cap) begin
                        cnt_q      <= '0;
                        rx_data_o  <= rx_next;
                        rx_valid_o <= 1'b1;
                        tx_sh_q    <= hold_i;
                        done_q     <= ~cpha_i;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end else if (evt_i.launch && cnt_q != '0) begin
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign tx_msb_o = tx_sh_q[DATA_W-1];

endmodule

// File: rtl/spi_target_port.sv
// SPI target port: synchronizes the serial inputs, detects edges, and
// shifts bytes MSB first. The transmit side has a holding register.
// Assumes: the system clock runs at least 4x the serial clock rate.
module spi_target_port
    import spt_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SYNC_STAGES = SPT_SYNC_DEPTH
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              sclk_i,
    input  logic              ss_ni,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_wr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);

    // Channel order is {mosi, ss, sclk}; select resets to its idle high.
    localparam int unsigned N_CHAN = 3;
    localparam logic [N_CHAN-1:0] CHAN_RST = 3'b010;

    logic [N_CHAN-1:0] raw_in, synced;
    logic [DATA_W-1:0] hold;
    spt_evt_t          evt;

    assign raw_in = {mosi_i, ss_ni, sclk_i};

    spt_sync #(
        .STAGES   (SYNC_STAGES),
        .WIDTH    (N_CHAN),
        .RESET_VAL(CHAN_RST)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(raw_in),
        .sync_o (synced)
    );

    spt_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cpol_i  (cpol_i),
        .cpha_i  (cpha_i),
        .sclk_s_i(synced[0]),
        .ss_s_i  (synced[1]),
        .mosi_s_i(synced[2]),
        .evt_o   (evt)
    );

    spt_txhold #(.DATA_W(DATA_W)) u_hold (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wr_i  (tx_wr_i),
        .data_i(tx_data_i),
        .hold_o(hold)
    );

    spt_engine #(.DATA_W(DATA_W)) u_engine (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cpha_i    (cpha_i),
        .evt_i     (evt),
        .hold_i    (hold),
        .tx_msb_o  (miso_o),
        .rx_data_o (rx_data_o),
        .rx_valid_o(rx_valid_o)
    );

    // Drive the shared return line only while the select pin is low.
    assign miso_oe_o = ~ss_ni;

endmodule

// File: rtl/spt_checker.sv
// Protocol checker for spi_target_port, bound to the top module.
// Assumes: synchronous active-low reset on rst_ni.
module spt_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              miso_i,
    input logic              rx_valid_i,
    input logic [DATA_W-1:0] rx_data_i,
    input logic              sel_i,
    input logic              capture_i,
    input logic              launch_i
);

    assert_valid_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |=> !rx_valid_i);

    assert_rxdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_valid_i |-> $stable(rx_data_i));

    assert_valid_after_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |-> $past(capture_i));

    assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> !rx_valid_i);

    // R5: while selected, the output bit moves only on a launch or at byte end.
    assert_shift_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && !launch_i) |=> ($stable(miso_i) || rx_valid_i));

endmodule

bind spi_target_port spt_checker #(.DATA_W(DATA_W)) u_spt_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .miso_i    (miso_o),
    .rx_valid_i(rx_valid_o),
    .rx_data_i (rx_data_o),
    .sel_i     (evt.sel),
    .capture_i (evt.capture),
    .launch_i  (evt.launch)
);

// File: tb/spi_target_port_tb_top.sv
// Bench for spi_target_port. It acts as the master: directed corner
// cases first, then random transfers from a fixed seed.
module spi_target_port_tb_top;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0;
    logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso_o, miso_oe_o;
    logic [7:0] tx_data = 8'h00;
    logic       tx_wr = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_valid_o;

    int vectors = 0;
    int fails = 0;
    int pulses = 0;
    bit finished = 0;
    logic [7:0] hold_m = 8'h00;

    spi_target_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha),
        .sclk_i(sclk), .ss_ni(ss_n), .mosi_i(mosi), .miso_o(miso_o),
        .miso_oe_o(miso_oe_o), .tx_data_i(tx_data), .tx_wr_i(tx_wr),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (rx_valid_o) pulses++;

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input bit p, input bit h);
        cpol = p; cpha = h; sclk = p;
        cyc(6);
    endtask

    task automatic write_tx(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; hold_m = v;
        cyc(1);
        tx_wr = 1'b0;
    endtask

    // Wait before a capture edge; optionally write the holding register.
    task automatic wait_pre(input bit do_wr, input logic [7:0] wv);
        if (do_wr) begin
            write_tx(wv);
            cyc(HALF - 1);
        end else begin
            cyc(HALF);
        end
    endtask

    // Wait after a capture edge; on the eighth bit check valid timing (R10).
    task automatic wait_post(input bit last, input logic [7:0] mo);
        if (last) begin
            cyc(2);
            check(rx_valid_o == 1'b0, "R10 early valid", {7'd0, rx_valid_o}, 8'h00);
            cyc(1);
            check(rx_valid_o == 1'b1, "R10 valid on third edge", {7'd0, rx_valid_o}, 8'h01);
            check(rx_data_o == mo, "R3 received byte", rx_data_o, mo);
            cyc(1);
            check(rx_valid_o == 1'b0, "R10 single cycle", {7'd0, rx_valid_o}, 8'h00);
        end else begin
            cyc(HALF);
        end
    endtask

    // Shift nbits with the current mode; a write of wv happens at bit wr_at.
    task automatic shift_bits(input logic [7:0] mo, input int nbits, input int wr_at,
                              input logic [7:0] wv, output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi = mo[7-i];
                wait_pre(i == wr_at, wv);
                mi = {mi[6:0], miso_o};
                sclk = ~cpol;
                wait_post(i == 7, mo);
                sclk = cpol;
            end else begin
                sclk = ~cpol;
                mosi = mo[7-i];
                wait_pre(i == wr_at, wv);
                mi = {mi[6:0], miso_o};
                sclk = cpol;
                wait_post(i == 7, mo);
            end
        end
    endtask

    task automatic select(input logic [7:0] exp_byte);
        ss_n = 1'b0;
        #1;
        check(miso_oe_o == 1'b1, "R1 oe while selected", {7'd0, miso_oe_o}, 8'h01);
        check(miso_o == exp_byte[7], "R2 MSB before first edge", {7'd0, miso_o}, {7'd0, exp_byte[7]});
    endtask

    task automatic deselect();
        cyc(HALF);
        ss_n = 1'b1;
        #1;
        check(miso_oe_o == 1'b0, "R1 released when deselected", {7'd0, miso_oe_o}, 8'h00);
        cyc(6);
    endtask

    // One phase-zero byte with its own select pulse.
    task automatic xfer_ph0(input logic [7:0] mo, input int wr_at, input logic [7:0] wv, input string req);
        logic [7:0] exp, got;
        exp = hold_m;
        select(exp);
        shift_bits(mo, 8, wr_at, wv, got);
        check(got == exp, req, got, exp);
        deselect();
    endtask

    initial begin
        void'($urandom(32'd2718));
        cyc(5);
        check(miso_oe_o == 1'b0, "R1 reset oe", {7'd0, miso_oe_o}, 8'h00);
        check(rx_valid_o == 1'b0, "R10 reset valid", {7'd0, rx_valid_o}, 8'h00);
        rst_n = 1'b1;
        cyc(3);
        check(rx_data_o == 8'h00, "R10 reset data", rx_data_o, 8'h00);

        // R7: all four modes, both directions.
        for (int m = 0; m < 4; m++) begin
            logic [7:0] got;
            set_mode(m[1], m[0]);
            write_tx(8'hA5 ^ 8'(m * 8'h31));
            cyc(4);
            if (!m[0]) begin
                xfer_ph0(8'h3C ^ 8'(m), -1, 8'h00, "R7 ph0 transmit");
            end else begin
                select(hold_m);
                shift_bits(8'hC3 ^ 8'(m), 8, -1, 8'h00, got);
                check(got == hold_m, "R7 ph1 transmit", got, hold_m);
                deselect();
            end
        end

        // R5 and R6: write during a byte goes to the next byte; no write repeats.
        set_mode(1'b0, 1'b0);
        write_tx(8'h81);
        cyc(4);
        xfer_ph0(8'h11, 3, 8'h5E, "R5 current byte unchanged");
        check(hold_m == 8'h5E, "R5 model", hold_m, 8'h5E);
        xfer_ph0(8'h22, -1, 8'h00, "R5 new value in next byte");
        xfer_ph0(8'h33, -1, 8'h00, "R6 repeat previous value");

        // R4: extra clock edges after a full byte are ignored.
        begin
            logic [7:0] got;
            int p0;
            select(hold_m);
            shift_bits(8'h96, 8, -1, 8'h00, got);
            #1 p0 = pulses;
            for (int k = 0; k < 8; k++) begin
                mosi = k[0];
                cyc(HALF); sclk = 1'b1;
                cyc(HALF); sclk = 1'b0;
            end
            cyc(6);
            #1;
            check(pulses == p0, "R4 no valid without select toggle", 8'(pulses - p0), 8'h00);
            check(rx_data_o == 8'h96, "R4 data unchanged", rx_data_o, 8'h96);
            deselect();
        end

        // R9: partial byte dropped, next transfer restarts at bit 7.
        for (int m = 0; m < 2; m++) begin
            logic [7:0] got;
            int p0;
            set_mode(1'b1, m[0]);
            #1 p0 = pulses;
            select(hold_m);
            shift_bits(8'hF0, 5, -1, 8'h00, got);
            deselect();
            #1;
            check(pulses == p0, "R9 no valid on partial byte", 8'(pulses - p0), 8'h00);
            check(rx_data_o != 8'hF0, "R9 partial not stored", rx_data_o, 8'h96);
            select(hold_m);
            shift_bits(8'h4D, 8, -1, 8'h00, got);
            check(got == hold_m, "R9 restart transmit", got, hold_m);
            deselect();
        end

        // R8: three bytes under one select in phase 1, writes during bytes.
        set_mode(1'b0, 1'b1);
        write_tx(8'h17);
        cyc(4);
        begin
            logic [7:0] exp, got;
            select(hold_m);
            for (int b = 0; b < 3; b++) begin
                exp = hold_m;
                shift_bits(8'h60 + 8'(b), 8, (b < 2) ? 2 : -1, 8'hE0 + 8'(b), got);
                check(got == exp, "R8 multi-byte transmit", got, exp);
            end
            deselect();
        end

        // Random transfers in random modes.
        for (int n = 0; n < 40; n++) begin
            logic [7:0] mo, wv, exp, got;
            bit p, h, mid;
            int nb;
            p = 1'($urandom); h = 1'($urandom);
            set_mode(p, h);
            if ($urandom_range(3) != 0) begin
                write_tx(8'($urandom));
                cyc(4);
            end
            mo = 8'($urandom);
            wv = 8'($urandom);
            mid = ($urandom_range(2) == 0);
            nb = h ? int'($urandom_range(3, 1)) : 1;
            select(hold_m);
            for (int b = 0; b < nb; b++) begin
                exp = hold_m;
                shift_bits(mo ^ 8'(b), 8, mid ? 4 : -1, wv ^ 8'(b), got);
                check(got == exp, h ? "R8 random transmit" : "R3 random transmit", got, exp);
            end
            deselect();
        end

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule